// File: doc/BRIEF.md
# Wide Compare Timer

A free-running up-counter, 64 bits wide by default, paired with a comparator of the same width. Software reaches both through a narrow single-cycle register port: a byte address, a write strobe with write data, and a read strobe whose result appears on the registered read-data output one clock later. Because the count and the compare value are wider than the port, each is split into a low word and a high word. Software reads a consistent count by reading the high word, then the low word, then the high word again, and retrying whenever the two high words differ.

When the comparator is armed and the full count reaches or passes the compare value, a sticky event flag is raised. Software clears the flag by writing a one to it. The interrupt output is the flag gated by an interrupt enable and is meant for an edge-sensitive interrupt input. An optional auto-increment mode adds a programmable step to the compare value on every match, which gives periodic events without software reloading the comparator. The counter can be loaded only while it is stopped, which is how software zeroes it before starting.

Top module: `wide_cmp_timer`

## Requirements
- R1: After a synchronous reset, the count, compare value, step register, control bits, event flag, read data and interrupt are all zero.
- R2: While control bit 0 (run) is 1, the count goes up by exactly 1 on every clock and wraps modulo 2^64.
- R3: While run is 0, the count holds its value. A write to offset 0x00 loads the low 32 bits of the count and a write to 0x04 loads the high 32 bits.
- R4: Writes to offsets 0x00 or 0x04 made while run is 1 are ignored, and counting continues undisturbed.
- R5: When control bit 1 (compare enable) is 1 and the unsigned 64-bit count is greater than or equal to the 64-bit compare value (low word at 0x10, high word at 0x14), status bit 0 (offset 0x0C) is 1 after the next clock edge. Equality of the low words alone does not count as a match.
- R6: The irq output equals status bit 0 ANDed with control bit 2 (interrupt enable), and it changes on the same edge as those two registers.
- R7: Writing 1 to status bit 0 clears the flag, unless a match occurs in that same cycle, in which case the flag stays set. Writing 0 to the bit has no effect.
- R8: When control bit 3 (auto-increment) is 1, every match cycle replaces the compare value with itself plus the zero-extended 32-bit step register at offset 0x18. A software write to a compare word in the same cycle takes precedence over the increment.
- R9: A read strobe loads read data on the next edge with the addressed register as it was before that edge. Control reads back in bits [3:0], status in bit 0, and unmapped offsets read as zero. Read data holds its value when no read is strobed.
- R10: Reading high, low, high across a carry out of the low word and retrying on a high-word mismatch always yields a 64-bit value that is consistent with the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Interrupt, event flag gated by the enable |

## Verification
The checker watches the per-cycle rules on every clock. These are the single-step increment while running, the hold while stopped or when a load is refused, flag set on a match, the clear that succeeds only when no match is present, irq never being raised without the flag, and the compare value advancing by exactly the step on an auto-increment match. Other behaviour depends on how the software sequences its accesses, so only the bench scenarios can show it. That covers the high/low/high read that crosses a carry, the precedence of a software compare write over a simultaneous increment, the rejection of a low-word-only match, and the read-back timing. The bench's cycle model compares read data and irq on every clock throughout those scenarios.

// File: rtl/wct_pkg.sv
package wct_pkg;

  // Byte offsets of the register port (software decodes these)
  localparam int OFF_CNT  = 'h00;  // count words at OFF_CNT + 4*i
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_CMP  = 'h10;  // compare words at OFF_CMP + 4*i
  localparam int OFF_INC  = 'h18;

  localparam int CTRL_W = 4;

  // Bit order is visible to software: run is bit 0, auto_inc bit 3
  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/wct_counter.sv
module wct_counter #(
  parameter  int DATA_W = 32,
  parameter  int NWORDS = 2,
  localparam int CNT_W  = DATA_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [NWORDS-1:0] load,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (run) begin
      count_nxt = count + CNT_W'(1);
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (load[i]) count_nxt[i*DATA_W +: DATA_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

endmodule

// File: rtl/wct_compare.sv
module wct_compare #(
  parameter  int DATA_W = 32,
  parameter  int NWORDS = 2,
  localparam int CNT_W  = DATA_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_en,
  input  logic              auto_inc,
  input  logic [CNT_W-1:0]  count,
  input  logic [NWORDS-1:0] cmp_load,
  input  logic              inc_load,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic [DATA_W-1:0] step,
  output logic              evt,
  output logic              evt_nxt
);

  logic             match;
  logic [CNT_W-1:0] cmp_nxt;
  logic [CNT_W-1:0] step_ext;

  assign step_ext = {{(CNT_W-DATA_W){1'b0}}, step};
  assign match    = cmp_en && (count >= cmp);

  // Software word write wins over the auto-increment in the same cycle
  always_comb begin
    cmp_nxt = cmp;
    if (|cmp_load) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (cmp_load[i]) cmp_nxt[i*DATA_W +: DATA_W] = wdata;
      end
    end else if (match && auto_inc) begin
      cmp_nxt = cmp + step_ext;
    end
  end

  // A live match overrides a write-one-to-clear
  always_comb begin
    evt_nxt = evt;
    if (match)                   evt_nxt = 1'b1;
    else if (stat_wr && wdata[0]) evt_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      step <= '0;
      evt  <= 1'b0;
    end else begin
      cmp <= cmp_nxt;
      evt <= evt_nxt;
      if (inc_load) step <= wdata;
    end
  end

endmodule

// File: rtl/wct_readback.sv
module wct_readback
  import wct_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NWORDS = 2,
  parameter  int ADDR_W = 5,
  localparam int CNT_W  = DATA_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [DATA_W-1:0] step,
  input  ctrl_t             ctrl,
  input  logic              evt,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (addr == ADDR_W'(OFF_CNT + 4*i)) word = count[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFF_CMP + 4*i)) word = cmp[i*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(OFF_CTRL)) word = DATA_W'(ctrl);
    if (addr == ADDR_W'(OFF_STAT)) word = DATA_W'(evt);
    if (addr == ADDR_W'(OFF_INC))  word = step;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end

endmodule

// File: rtl/wide_cmp_timer.sv
module wide_cmp_timer
  import wct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORDS = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int CNT_W = DATA_W * NWORDS;

  logic [NWORDS-1:0] cnt_load;
  logic [NWORDS-1:0] cmp_load;
  logic              ctrl_wr;
  logic              stat_wr;
  logic              inc_wr;
  ctrl_t             ctrl;
  ctrl_t             ctrl_nxt;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cmp;
  logic [DATA_W-1:0] step;
  logic              evt;
  logic              evt_nxt;

  // Address decode, one strobe per word of each wide register
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign cnt_load[g] = wr_en && (addr == ADDR_W'(OFF_CNT + 4*g));
    assign cmp_load[g] = wr_en && (addr == ADDR_W'(OFF_CMP + 4*g));
  end

  assign ctrl_wr = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign stat_wr = wr_en && (addr == ADDR_W'(OFF_STAT));
  assign inc_wr  = wr_en && (addr == ADDR_W'(OFF_INC));

  assign ctrl_nxt = ctrl_wr ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      irq  <= 1'b0;
    end else begin
      ctrl <= ctrl_nxt;
      irq  <= evt_nxt && ctrl_nxt.irq_en;
    end
  end

  wct_counter #(.DATA_W(DATA_W), .NWORDS(NWORDS)) i_counter (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl.run),
    .load  (cnt_load),
    .wdata (wdata),
    .count (count)
  );

  wct_compare #(.DATA_W(DATA_W), .NWORDS(NWORDS)) i_compare (
    .clk      (clk),
    .rst      (rst),
    .cmp_en   (ctrl.cmp_en),
    .auto_inc (ctrl.auto_inc),
    .count    (count),
    .cmp_load (cmp_load),
    .inc_load (inc_wr),
    .stat_wr  (stat_wr),
    .wdata    (wdata),
    .cmp      (cmp),
    .step     (step),
    .evt      (evt),
    .evt_nxt  (evt_nxt)
  );

  wct_readback #(.DATA_W(DATA_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) i_readback (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .count (count),
    .cmp   (cmp),
    .step  (step),
    .ctrl  (ctrl),
    .evt   (evt),
    .rdata (rdata)
  );

endmodule

// File: rtl/wct_checker.sv
module wct_checker
  import wct_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NWORDS = 2,
  parameter  int ADDR_W = 5,
  localparam int CNT_W  = DATA_W * NWORDS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cmp,
  input logic [DATA_W-1:0] step,
  input logic              evt,
  input logic              irq
);

  logic cnt_hit;
  logic cmp_hit;
  logic stat_clr;
  logic live;

  always_comb begin
    cnt_hit = 1'b0;
    cmp_hit = 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      if (wr_en && addr == ADDR_W'(OFF_CNT + 4*i)) cnt_hit = 1'b1;
      if (wr_en && addr == ADDR_W'(OFF_CMP + 4*i)) cmp_hit = 1'b1;
    end
  end

  assign stat_clr = wr_en && (addr == ADDR_W'(OFF_STAT)) && wdata[0];
  assign live     = ctrl.cmp_en && (count >= cmp);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.run |=> count == $past(count) + CNT_W'(1));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !cnt_hit) |=> $stable(count));

  p_load_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && cnt_hit) |=> count == $past(count) + CNT_W'(1));

  p_match_sets_r5: assert property (@(posedge clk) disable iff (rst)
    live |=> evt);

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> evt);

  p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !live) |=> !evt);

  p_auto_step_r8: assert property (@(posedge clk) disable iff (rst)
    (live && ctrl.auto_inc && !cmp_hit) |=>
      cmp == $past(cmp) + {{(CNT_W-DATA_W){1'b0}}, $past(step)});

endmodule

bind wide_cmp_timer wct_checker #(.DATA_W(DATA_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) i_checker (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .ctrl  (ctrl),
  .count (count),
  .cmp   (cmp),
  .step  (step),
  .evt   (evt),
  .irq   (irq)
);

// File: tb/test_wide_cmp_timer.sv
module test_wide_cmp_timer;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                            A_STA = 5'h0C, A_KLO = 5'h10, A_KHI = 5'h14,
                            A_STP = 5'h18, A_NONE = 5'h1C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  wide_cmp_timer i_wide_cmp_timer (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step, m_rd;
  logic [3:0]  m_ctl;
  logic        m_evt, m_irq;

  always @(posedge clk) begin : model
    logic hit;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_rd = 0;
      m_ctl = 0; m_evt = 0; m_irq = 0;
    end else begin
      hit = m_ctl[1] && (m_cnt >= m_cmp);
      if (rd_en) begin
        case (addr)
          A_CLO:   m_rd = m_cnt[31:0];
          A_CHI:   m_rd = m_cnt[63:32];
          A_CTL:   m_rd = {28'd0, m_ctl};
          A_STA:   m_rd = {31'd0, m_evt};
          A_KLO:   m_rd = m_cmp[31:0];
          A_KHI:   m_rd = m_cmp[63:32];
          A_STP:   m_rd = m_step;
          default: m_rd = 0;
        endcase
      end
      if (m_ctl[0])                    m_cnt = m_cnt + 1;
      else if (wr_en && addr == A_CLO) m_cnt[31:0] = wdata;
      else if (wr_en && addr == A_CHI) m_cnt[63:32] = wdata;
      if (wr_en && addr == A_KLO)      m_cmp[31:0] = wdata;
      else if (wr_en && addr == A_KHI) m_cmp[63:32] = wdata;
      else if (hit && m_ctl[3])        m_cmp = m_cmp + {32'd0, m_step};
      if (wr_en && addr == A_STP) m_step = wdata;
      if (hit) m_evt = 1;
      else if (wr_en && addr == A_STA && wdata[0]) m_evt = 0;
      if (wr_en && addr == A_CTL) m_ctl = wdata[3:0];
      m_irq = m_evt && m_ctl[2];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 rdata vs model", {32'd0, rdata}, {32'd0, m_rd});
      chk("R6 irq vs model", {63'd0, irq}, {63'd0, m_irq});
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-to-end run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin : stim
    logic [31:0] a, b, h0, lo, h1;
    bit done;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    rd(A_CTL, a); chk("R1 control reset", {32'd0, a}, 64'd0);
    rd(A_CLO, a); chk("R1 count reset", {32'd0, a}, 64'd0);

    // R3 load while stopped, R9 unmapped read
    wr(A_CLO, 32'hFFFF_FFE0);
    wr(A_CHI, 32'd5);
    rd(A_CLO, a); chk("R3 low word loaded and held", {32'd0, a}, 64'hFFFF_FFE0);
    rd(A_CHI, a); chk("R3 high word loaded", {32'd0, a}, 64'd5);
    rd(A_NONE, a); chk("R9 unmapped reads zero", {32'd0, a}, 64'd0);

    // R10 high/low/high across the low-word carry
    wr(A_CTL, 32'h1);
    done = 0;
    for (int k = 0; k < 40 && !done; k++) begin
      rd(A_CHI, h0); rd(A_CLO, lo); rd(A_CHI, h1);
      if (h0 == h1) begin
        chk("R10 consistent split read",
            {63'd0, ((h1 == 5 && lo >= 32'hFFFF_FF00) || (h1 == 6 && lo < 32'h100))}, 64'd1);
        if (h1 == 6) done = 1;
      end
    end
    chk("R10 carry crossed", {63'd0, done}, 64'd1);

    // R2 step of one per clock (reads two cycles apart)
    rd(A_CLO, a); rd(A_CLO, b);
    chk("R2 count step", {32'd0, b - a}, 64'd2);

    // R4 load ignored while running (reads four cycles apart)
    rd(A_CLO, a); wr(A_CLO, 32'd0); rd(A_CLO, b);
    chk("R4 running load ignored", {32'd0, b - a}, 64'd4);

    // R5/R6/R7 compare, flag, irq, clear
    wr(A_CTL, 32'h0); wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(A_KLO, 32'd20); wr(A_KHI, 32'd0);
    wr(A_CTL, 32'h7);
    chk("R5 no event before match", {63'd0, irq}, 64'd0);
    repeat (40) @(negedge clk);
    rd(A_STA, a); chk("R5 event after match", {32'd0, a}, 64'd1);
    chk("R6 irq with enable", {63'd0, irq}, 64'd1);
    wr(A_STA, 32'h1);
    rd(A_STA, a); chk("R7 live match keeps flag", {32'd0, a}, 64'd1);
    wr(A_CTL, 32'h5);
    wr(A_STA, 32'h0);
    rd(A_STA, a); chk("R7 write zero no effect", {32'd0, a}, 64'd1);
    wr(A_STA, 32'h1);
    rd(A_STA, a); chk("R7 write one clears", {32'd0, a}, 64'd0);
    chk("R6 irq drops with flag", {63'd0, irq}, 64'd0);

    // R6 masked interrupt
    wr(A_CTL, 32'h3);
    repeat (4) @(negedge clk);
    rd(A_STA, a); chk("R6 flag set while masked", {32'd0, a}, 64'd1);
    chk("R6 irq masked", {63'd0, irq}, 64'd0);

    // R5 full-width compare: low words equal, high word behind
    wr(A_CTL, 32'h0); wr(A_CLO, 32'd0); wr(A_CHI, 32'd1);
    wr(A_KLO, 32'd0); wr(A_KHI, 32'd2);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'h3);
    repeat (20) @(negedge clk);
    rd(A_STA, a); chk("R5 no match on low word only", {32'd0, a}, 64'd0);

    // R8 auto-increment: match at 10 then 35 then 60
    wr(A_CTL, 32'h0); wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(A_KLO, 32'd10); wr(A_KHI, 32'd0); wr(A_STP, 32'd25);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'hF);
    repeat (12) @(negedge clk);
    rd(A_KLO, a); chk("R8 first re-arm", {32'd0, a}, 64'd35);
    repeat (30) @(negedge clk);
    rd(A_KLO, a); chk("R8 second re-arm", {32'd0, a}, 64'd60);

    // R8 software compare write beats a same-cycle increment
    wr(A_CTL, 32'h0); wr(A_CLO, 32'd100);
    wr(A_KLO, 32'd0); wr(A_STP, 32'd1);
    wr(A_CTL, 32'hF);
    wr(A_KLO, 32'd5);
    rd(A_KLO, a); chk("R8 write precedence", {32'd0, a}, 64'd6);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule